// File: doc/BRIEF.md
# Speculative L1 Tag Controller with Squash Undo

This block is the tag and control side of a small set-associative L1 data cache that can take back what speculative loads did to it. Every load carries a speculation epoch. On a miss the controller installs the tag right away, issues a fetch for the line's data, and writes an entry into an undo log. The entry holds the installed address, the way used, and the address of the line that was pushed out. Hits write nothing into the log. Victims come from a stateless pseudo-random choice, so a hit never changes any state that would later need undoing.

When the pipeline squashes an epoch, the controller walks the log from the youngest entry to the oldest and handles one entry per cycle. For each entry that carries the squashed epoch, it invalidates the installed line if that line is still present. If the entry also evicted a valid line, it asks the next level for that line again over a valid/ready channel. It then waits for the matching fill and puts the line back into the cache.

While this runs, a busy output holds the pipeline. A load that arrives anyway is answered as a miss and leaves no trace, so a line whose cleanup is still pending can never show up as a hit.

Top module: `spec_undo_l1`

## Requirements
- R1: A load is answered one cycle after it is presented. On a miss the tag is installed and a fetch for the load's address is issued in that same response cycle. A later load of the same address hits.
- R2: The victim is the lowest-numbered invalid way of the set if one exists, and otherwise a way picked by a free-running 16-bit LFSR. A hit changes neither tags nor valid bits.
- R3: Squashing an epoch whose loads all hit produces no restore request.
- R4: After cleanup, a line installed by a squashed miss is no longer present, so loading it misses.
- R5: A squashed miss that evicted a valid line raises a restore request carrying that line's address. The request stays raised with the same address until it is accepted.
- R6: A returned restore fill installs the line again, so it hits afterwards. The line goes into its old way if that way is invalid, and into a random way otherwise.
- R7: busy_o is high from the cycle of the squash until the log walk has finished and every restore fill has returned.
- R8: A load presented while busy_o is high is answered as a miss, with no fetch and no change to the cache.
- R9: Cleanup handles log entries youngest first, so restore requests come out in reverse order of the squashed misses.
- R10: Only log entries whose epoch equals the squashed epoch are undone. Lines installed under other epochs stay present.
- R11: After reset, all lines are invalid and resp_valid_o, miss_valid_o, restore_valid_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request present |
| req_addr_i | input | LINE_W | Line address of the load; the low log2(SETS) bits select the set |
| req_epoch_i | input | EPOCH_W | Speculation epoch of the load |
| resp_valid_o | output | 1 | Response for the load presented in the previous cycle |
| resp_hit_o | output | 1 | The response is a hit |
| miss_valid_o | output | 1 | Fetch request for a missed line |
| miss_addr_o | output | LINE_W | Address to fetch |
| squash_i | input | 1 | Squash pulse |
| squash_epoch_i | input | EPOCH_W | Epoch to clean up |
| busy_o | output | 1 | Cleanup in progress; the pipeline must hold loads |
| restore_valid_o | output | 1 | Restore request valid |
| restore_ready_i | input | 1 | Next level accepts the restore request |
| restore_addr_o | output | LINE_W | Address of the evicted line to fetch again |
| fill_valid_i | input | 1 | Restore fill returned |
| fill_addr_i | input | LINE_W | Address of the returned fill |

## Verification
The bench builds the block with its defaults: four sets of two ways, 8-bit line addresses and an eight-entry undo log. With this geometry two loads fill a set and a third forces an eviction, so every install, eviction and restore path can be reached within a few loads per set. The LFSR makes the victim unpredictable, so the bench accepts either resident line as the restored address. It then confirms the outcome through later hits and misses. The short log means a squash walks every entry in a few cycles, and two squashed misses in different sets show the youngest-first order directly.

// File: rtl/spec_undo_pkg.sv
package spec_undo_pkg;
  typedef enum logic [1:0] {CU_IDLE, CU_WALK, CU_REQ, CU_WAIT} cu_state_e;
endpackage

// File: rtl/su_lfsr.sv
module su_lfsr #(
  parameter int          OUT_W = 1,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [15:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= SEED;
    else         s_q <= (s_q >> 1) ^ (s_q[0] ? 16'hB400 : 16'h0000);
  end

  assign rnd_o = s_q[OUT_W-1:0];
endmodule

// File: rtl/su_undo_log.sv
module su_undo_log #(
  parameter int DEPTH   = 8,
  parameter int EPOCH_W = 4,
  parameter int LINE_W  = 8,
  parameter int WAY_W   = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [EPOCH_W-1:0]       wr_epoch_i,
  input  logic [LINE_W-1:0]        wr_ins_i,
  input  logic [WAY_W-1:0]         wr_way_i,
  input  logic                     wr_ev_valid_i,
  input  logic [LINE_W-1:0]        wr_ev_i,
  output logic [$clog2(DEPTH)-1:0] head_o,
  input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
  output logic                     rd_valid_o,
  output logic [EPOCH_W-1:0]       rd_epoch_o,
  output logic [LINE_W-1:0]        rd_ins_o,
  output logic [WAY_W-1:0]         rd_way_o,
  output logic                     rd_ev_valid_o,
  output logic [LINE_W-1:0]        rd_ev_o,
  input  logic                     clr_en_i
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0]              valid_q;
  logic [DEPTH-1:0]              ev_valid_q;
  logic [DEPTH-1:0][EPOCH_W-1:0] epoch_q;
  logic [DEPTH-1:0][LINE_W-1:0]  ins_q;
  logic [DEPTH-1:0][LINE_W-1:0]  ev_q;
  logic [DEPTH-1:0][WAY_W-1:0]   way_q;
  logic [PTR_W-1:0]              head_q;

  // ring: oldest entries are overwritten, they are treated as retired
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      ev_valid_q <= '0;
      epoch_q    <= '0;
      ins_q      <= '0;
      ev_q       <= '0;
      way_q      <= '0;
      head_q     <= '0;
    end else begin
      if (clr_en_i) valid_q[rd_idx_i] <= 1'b0;
      if (wr_en_i) begin
        valid_q[head_q]    <= 1'b1;
        ev_valid_q[head_q] <= wr_ev_valid_i;
        epoch_q[head_q]    <= wr_epoch_i;
        ins_q[head_q]      <= wr_ins_i;
        ev_q[head_q]       <= wr_ev_i;
        way_q[head_q]      <= wr_way_i;
        head_q             <= head_q + 1'b1;
      end
    end
  end

  assign head_o        = head_q;
  assign rd_valid_o    = valid_q[rd_idx_i];
  assign rd_epoch_o    = epoch_q[rd_idx_i];
  assign rd_ins_o      = ins_q[rd_idx_i];
  assign rd_way_o      = way_q[rd_idx_i];
  assign rd_ev_valid_o = ev_valid_q[rd_idx_i];
  assign rd_ev_o       = ev_q[rd_idx_i];
endmodule

// File: rtl/spec_undo_l1.sv
module spec_undo_l1
  import spec_undo_pkg::*;
#(
  parameter int SETS      = 4,
  parameter int WAYS      = 2,
  parameter int LINE_W    = 8,
  parameter int EPOCH_W   = 4,
  parameter int LOG_DEPTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [LINE_W-1:0]  req_addr_i,
  input  logic [EPOCH_W-1:0] req_epoch_i,
  output logic               resp_valid_o,
  output logic               resp_hit_o,
  output logic               miss_valid_o,
  output logic [LINE_W-1:0]  miss_addr_o,
  input  logic               squash_i,
  input  logic [EPOCH_W-1:0] squash_epoch_i,
  output logic               busy_o,
  output logic               restore_valid_o,
  input  logic               restore_ready_i,
  output logic [LINE_W-1:0]  restore_addr_o,
  input  logic               fill_valid_i,
  input  logic [LINE_W-1:0]  fill_addr_i
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = LINE_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int PTR_W = $clog2(LOG_DEPTH);
  localparam int CNT_W = PTR_W + 1;

  cu_state_e state_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0]            vld_q;
  logic [EPOCH_W-1:0] sq_epoch_q;
  logic [PTR_W-1:0]   walk_ptr_q;
  logic [CNT_W-1:0]   walk_cnt_q;
  logic [LINE_W-1:0]  rst_addr_q;
  logic [WAY_W-1:0]   rst_way_q;
  logic               resp_valid_q, resp_hit_q, miss_valid_q;
  logic [LINE_W-1:0]  miss_addr_q;

  logic [WAY_W-1:0] rnd_way;
  su_lfsr #(.OUT_W(WAY_W)) u_lfsr (.clk_i, .rst_ni, .rnd_o(rnd_way));

  // lookup
  logic [IDX_W-1:0] r_set;
  logic [TAG_W-1:0] r_tag;
  logic             hit, any_inv, accept;
  logic [WAY_W-1:0] inv_way, victim;
  assign r_set = req_addr_i[IDX_W-1:0];
  assign r_tag = req_addr_i[LINE_W-1:IDX_W];

  always_comb begin
    hit     = 1'b0;
    any_inv = 1'b0;
    inv_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld_q[r_set][w] && tag_q[r_set][w] == r_tag) hit = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[r_set][w]) begin
        any_inv = 1'b1;
        inv_way = WAY_W'(w);
      end
  end

  assign victim = any_inv ? inv_way : rnd_way;
  assign busy_o = (state_q != CU_IDLE) || squash_i;
  assign accept = req_valid_i && !busy_o;

  // undo log
  logic [PTR_W-1:0]   head;
  logic               rd_valid, rd_ev_valid, match, clr_en;
  logic [EPOCH_W-1:0] rd_epoch;
  logic [LINE_W-1:0]  rd_ins, rd_ev;
  logic [WAY_W-1:0]   rd_way;

  su_undo_log #(.DEPTH(LOG_DEPTH), .EPOCH_W(EPOCH_W), .LINE_W(LINE_W), .WAY_W(WAY_W)) u_log (
    .clk_i, .rst_ni,
    .wr_en_i(accept && !hit), .wr_epoch_i(req_epoch_i), .wr_ins_i(req_addr_i),
    .wr_way_i(victim), .wr_ev_valid_i(vld_q[r_set][victim]),
    .wr_ev_i({tag_q[r_set][victim], r_set}),
    .head_o(head), .rd_idx_i(walk_ptr_q),
    .rd_valid_o(rd_valid), .rd_epoch_o(rd_epoch), .rd_ins_o(rd_ins), .rd_way_o(rd_way),
    .rd_ev_valid_o(rd_ev_valid), .rd_ev_o(rd_ev), .clr_en_i(clr_en)
  );

  logic [IDX_W-1:0] w_set, f_set;
  logic [TAG_W-1:0] w_tag;
  logic [CNT_W-1:0] cnt_nxt;
  logic [WAY_W-1:0] fill_way;
  logic             fill_hit;
  assign w_set    = rd_ins[IDX_W-1:0];
  assign w_tag    = rd_ins[LINE_W-1:IDX_W];
  assign match    = rd_valid && rd_epoch == sq_epoch_q;
  assign clr_en   = (state_q == CU_WALK) && match;
  assign cnt_nxt  = walk_cnt_q + 1'b1;
  assign f_set    = rst_addr_q[IDX_W-1:0];
  assign fill_way = vld_q[f_set][rst_way_q] ? rnd_way : rst_way_q;
  assign fill_hit = fill_valid_i && fill_addr_i == rst_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= CU_IDLE;
      tag_q        <= '0;
      vld_q        <= '0;
      sq_epoch_q   <= '0;
      walk_ptr_q   <= '0;
      walk_cnt_q   <= '0;
      rst_addr_q   <= '0;
      rst_way_q    <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      miss_valid_q <= 1'b0;
      miss_addr_q  <= '0;
    end else begin
      resp_valid_q <= req_valid_i;
      resp_hit_q   <= accept && hit;
      miss_valid_q <= accept && !hit;
      miss_addr_q  <= req_addr_i;
      unique case (state_q)
        CU_IDLE: begin
          if (squash_i) begin
            sq_epoch_q <= squash_epoch_i;
            walk_ptr_q <= head - 1'b1;
            walk_cnt_q <= '0;
            state_q    <= CU_WALK;
          end else if (accept && !hit) begin
            tag_q[r_set][victim] <= r_tag;
            vld_q[r_set][victim] <= 1'b1;
          end
        end
        CU_WALK: begin
          walk_ptr_q <= walk_ptr_q - 1'b1;
          walk_cnt_q <= cnt_nxt;
          if (match && vld_q[w_set][rd_way] && tag_q[w_set][rd_way] == w_tag)
            vld_q[w_set][rd_way] <= 1'b0;
          if (match && rd_ev_valid) begin
            rst_addr_q <= rd_ev;
            rst_way_q  <= rd_way;
            state_q    <= CU_REQ;
          end else if (cnt_nxt == CNT_W'(LOG_DEPTH)) begin
            state_q <= CU_IDLE;
          end
        end
        CU_REQ: if (restore_ready_i) state_q <= CU_WAIT;
        CU_WAIT: begin
          if (fill_hit) begin
            tag_q[f_set][fill_way] <= rst_addr_q[LINE_W-1:IDX_W];
            vld_q[f_set][fill_way] <= 1'b1;
            state_q <= (walk_cnt_q == CNT_W'(LOG_DEPTH)) ? CU_IDLE : CU_WALK;
          end
        end
        default: state_q <= CU_IDLE;
      endcase
    end
  end

  assign resp_valid_o    = resp_valid_q;
  assign resp_hit_o      = resp_hit_q;
  assign miss_valid_o    = miss_valid_q;
  assign miss_addr_o     = miss_addr_q;
  assign restore_valid_o = (state_q == CU_REQ);
  assign restore_addr_o  = rst_addr_q;

  a_r1_resp_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
  a_r2_hit_keeps_tags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit) |=> ($stable(tag_q) && $stable(vld_q)));
  a_r5_restore_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_valid_o && !restore_ready_i) |=> (restore_valid_o && $stable(restore_addr_o)));
  a_r7_busy_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_valid_o |-> busy_o);
  a_r8_busy_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && busy_o) |=> (!miss_valid_o && !resp_hit_o));
  a_r8_busy_no_install: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CU_REQ) |=> $stable(vld_q));
endmodule

// File: tb/spec_undo_l1_tb.sv
module spec_undo_l1_tb;
  localparam int LINE_W = 8;
  localparam int EPOCH_W = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [LINE_W-1:0] req_addr_i = '0;
  logic [EPOCH_W-1:0] req_epoch_i = '0;
  logic resp_valid_o, resp_hit_o, miss_valid_o, busy_o, restore_valid_o;
  logic [LINE_W-1:0] miss_addr_o, restore_addr_o;
  logic squash_i = 1'b0;
  logic [EPOCH_W-1:0] squash_epoch_i = '0;
  logic restore_ready_i = 1'b0;
  logic fill_valid_i = 1'b0;
  logic [LINE_W-1:0] fill_addr_i = '0;

  spec_undo_l1 u_dut (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  logic [LINE_W+1:0] exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected {fetch, hit, addr}
  always @(negedge clk_i) begin
    if (rst_ni && resp_valid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R1 unexpected response", 1, 0);
      else begin
        logic [LINE_W+1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(resp_hit_o == e[LINE_W], {t, " hit"}, resp_hit_o, e[LINE_W]);
        check(miss_valid_o == e[LINE_W+1], {t, " fetch"}, miss_valid_o, e[LINE_W+1]);
        if (e[LINE_W+1])
          check(miss_addr_o == e[LINE_W-1:0], {t, " fetch addr"}, miss_addr_o, e[LINE_W-1:0]);
      end
    end
  end

  task automatic load(input logic [7:0] a, input logic [3:0] ep, input bit h, input bit f,
                      input string t);
    req_valid_i = 1'b1; req_addr_i = a; req_epoch_i = ep;
    exp_q.push_back({f, h, a});
    tag_q.push_back(t);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic squash(input logic [3:0] ep);
    squash_i = 1'b1; squash_epoch_i = ep;
    @(negedge clk_i);
    squash_i = 1'b0;
    check(busy_o == 1'b1, "R7 busy after squash", busy_o, 1);
  endtask

  task automatic wait_restore(output logic [7:0] a);
    int n = 0;
    while (!restore_valid_o && n < 40) begin @(negedge clk_i); n++; end
    check(restore_valid_o == 1'b1, "R5 restore request", restore_valid_o, 1);
    a = restore_addr_o;
  endtask

  task automatic accept_and_fill(input logic [7:0] a, input int dly);
    restore_ready_i = 1'b1;
    @(negedge clk_i);
    restore_ready_i = 1'b0;
    repeat (dly) @(negedge clk_i);
    check(busy_o == 1'b1, "R7 busy until fill", busy_o, 1);
    fill_valid_i = 1'b1; fill_addr_i = a;
    @(negedge clk_i);
    fill_valid_i = 1'b0;
  endtask

  task automatic wait_idle(output int restores);
    int n = 0;
    restores = 0;
    while (busy_o && n < 40) begin
      if (restore_valid_o) restores++;
      @(negedge clk_i); n++;
    end
    check(busy_o == 1'b0, "R7 busy drops", busy_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] ra, rb;
    int nr;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    check(!resp_valid_o && !miss_valid_o && !restore_valid_o && !busy_o, "R11 outputs idle",
          {resp_valid_o, miss_valid_o, restore_valid_o, busy_o}, 0);

    // R1 / R2: fill set 0 and set 1 with committed loads (epoch 0)
    load(8'h00, 0, 0, 1, "R1 miss 00");
    load(8'h04, 0, 0, 1, "R2 miss 04 into free way");
    load(8'h00, 0, 1, 0, "R1 hit 00");
    load(8'h04, 0, 1, 0, "R2 hit 04 kept");
    load(8'h01, 0, 0, 1, "R1 miss 01");
    load(8'h05, 0, 0, 1, "R1 miss 05");

    // R3: squashed hits need no cleanup
    load(8'h00, 2, 1, 0, "R3 hit ep2");
    @(negedge clk_i);
    squash(2);
    wait_idle(nr);
    check(nr == 0, "R3 no restore on squashed hit", nr, 0);
    load(8'h00, 0, 1, 0, "R3 line kept");

    // R4 / R5 / R6 / R7 / R8: one squashed miss evicting from full set 0
    load(8'h08, 3, 0, 1, "R1 spec miss 08");
    @(negedge clk_i);
    squash(3);
    wait_restore(ra);
    check(ra == 8'h00 || ra == 8'h04, "R5 restore addr is victim", ra, 0);
    load(8'h01, 0, 0, 0, "R8 load while busy is miss");
    restore_ready_i = 1'b1;
    @(negedge clk_i);
    restore_ready_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check(busy_o == 1'b1, "R7 busy waiting for fill", busy_o, 1);
    fill_valid_i = 1'b1; fill_addr_i = ra;
    @(negedge clk_i);
    fill_valid_i = 1'b0;
    wait_idle(nr);
    load(8'h00, 0, 1, 0, "R6 00 present");
    load(8'h04, 0, 1, 0, "R6 04 present");
    load(8'h01, 0, 1, 0, "R8 01 untouched");
    load(8'h05, 0, 1, 0, "R8 05 untouched");
    load(8'h08, 0, 0, 1, "R4 08 invalidated");

    // R9 / R10: two squashed misses, plus one under another epoch
    load(8'h02, 0, 0, 1, "R1 miss 02");
    load(8'h06, 0, 0, 1, "R1 miss 06");
    load(8'h03, 0, 0, 1, "R1 miss 03");
    load(8'h07, 0, 0, 1, "R1 miss 07");
    load(8'h09, 6, 0, 1, "R10 miss 09 ep6");
    load(8'h0A, 5, 0, 1, "R1 spec miss 0A");
    load(8'h0B, 5, 0, 1, "R1 spec miss 0B");
    @(negedge clk_i);
    squash(5);
    wait_restore(ra);
    check(ra == 8'h03 || ra == 8'h07, "R9 youngest restore first", ra, 3);
    repeat (3) begin
      @(negedge clk_i);
      check(restore_valid_o && restore_addr_o == ra, "R5 request held", restore_addr_o, ra);
    end
    accept_and_fill(ra, 2);
    wait_restore(rb);
    check(rb == 8'h02 || rb == 8'h06, "R9 older restore second", rb, 2);
    accept_and_fill(rb, 1);
    wait_idle(nr);
    check(nr == 0, "R7 no restore left", nr, 0);
    load(8'h02, 0, 1, 0, "R6 02 present");
    load(8'h06, 0, 1, 0, "R6 06 present");
    load(8'h03, 0, 1, 0, "R6 03 present");
    load(8'h07, 0, 1, 0, "R6 07 present");
    load(8'h09, 0, 1, 0, "R10 ep6 line kept");
    load(8'h0A, 0, 0, 1, "R4 0A invalidated");
    load(8'h0B, 0, 0, 1, "R4 0B invalidated");
    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R1 all responses seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule